// File: doc/BRIEF.md
# Multichannel DC-Blocking Decimator

This block is the first conditioning stage for a stream of multichannel biosignal samples. Samples arrive one per handshake on a valid/ready input, interleaved by channel in a fixed round-robin order starting with channel 0. For each channel, a first-order high-pass removes the DC offset. A short binomial low-pass FIR then band-limits the result. Only one frame in every `DECIM` is passed on, so the output rate is the input rate divided by `DECIM`. With the default of 40, a 1000 Hz input stream becomes a 25 Hz output stream.

The block serves `NUM_CH` channels (default 62) with one shared datapath. Per-channel filter history sits in small arrays addressed by the current channel number. All arithmetic is two's-complement fixed point. The DC blocker needs no multiplier because its pole is `a = 1 - 2^-NOTCH_K`. Each kept sample leaves with its channel number on a valid/ready output. When that output is stalled, the block stops taking input, so no sample is ever lost.

Top module: `eeg_prep_decim`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. All per-channel history, the channel counter and the frame phase are zero.
- R2: Each accepted sample `x` on channel `c` produces a high-pass value. The value is computed exactly as `v = x - xp + yp - (yp >>> NOTCH_K)`, using that channel's previous input `xp` and previous high-pass value `yp`. The shift is an arithmetic shift with floor rounding.
- R3: The low-pass output is `sum_k C(TAPS-1,k) * h[k]` shifted right arithmetically by `TAPS-1` bits. Here `h[0]` is the newest high-pass value of the channel and `h[k]` is the value from `k` frames earlier.
- R4: Channels are served round-robin from 0 to `NUM_CH-1`, and the first accepted sample after reset belongs to channel 0. Each channel's history changes only when a sample of that channel is accepted.
- R5: The frame phase advances by one, modulo `DECIM`, each time channel `NUM_CH-1` is accepted. A filtered sample is emitted only if it was accepted while the phase was 0. The first frame after reset is therefore emitted.
- R6: `out_ch` carries the channel number of the sample shown on `out_data`.
- R7: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_ch` hold their values.
- R8: A cycle without an input handshake changes no channel history, no counter and no phase.
- R9: The high-pass value saturates to the range from `-2^(DATA_W-1)` to `2^(DATA_W-1)-1` before it is stored or filtered further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take the input sample this cycle |
| in_data | input | DATA_W | Signed input sample of the current channel |
| out_valid | output | 1 | Filtered, decimated sample present |
| out_ready | input | 1 | Consumer takes the output sample this cycle |
| out_data | output | DATA_W | Signed filtered sample |
| out_ch | output | $clog2(NUM_CH) | Channel number of `out_data` |

## Verification
A channel counter that slips shows up at once on `out_ch` of the next emitted sample. It also shows in the data, because the history of the wrong channel gets used. A wrong frame phase either emits outputs in the 39 skipped frames or leaves a kept frame silent, and the first frame of each group exposes this within one frame. A corrupted history value or pole shift does not stay hidden. The DC blocker is recursive, so one wrong stored value stays in that channel's outputs for hundreds of frames, and the next emitted frame of that channel differs from the reference.

// File: rtl/eeg_prep_pkg.sv
package eeg_prep_pkg;

    // Binomial coefficient C(n,k); the running product stays exact at every step.
    function automatic int binom(input int n, input int k);
        int r;
        r = 1;
        for (int i = 0; i < k; i++) begin
            r = r * (n - i) / (i + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/dc_notch.sv
// First-order DC blocker: v = x - xp + yp - (yp >>> K), saturated to W bits.
module dc_notch #(
    parameter int W = 16,
    parameter int K = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] x_prev,
    input  logic [W-1:0] y_prev,
    output logic [W-1:0] y
);
    localparam int AW = W + 3;
    localparam logic signed [AW-1:0] MAXV = {{(AW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [AW-1:0] MINV = {{(AW-W+1){1'b1}}, {(W-1){1'b0}}};

    logic signed [AW-1:0] xe, xpe, ype, acc;

    always_comb begin
        xe  = AW'($signed(x));
        xpe = AW'($signed(x_prev));
        ype = AW'($signed(y_prev));
        acc = xe - xpe + ype - (ype >>> K);
        if (acc > MAXV)      y = MAXV[W-1:0];
        else if (acc < MINV) y = MINV[W-1:0];
        else                 y = acc[W-1:0];
    end
endmodule

// File: rtl/fir_binomial.sv
// Binomial low-pass with unity DC gain; taps[0] is the newest sample.
module fir_binomial
    import eeg_prep_pkg::*;
#(
    parameter int W    = 16,
    parameter int TAPS = 4
) (
    input  logic [TAPS-1:0][W-1:0] taps,
    output logic [W-1:0]           y
);
    localparam int AW = W + TAPS;
    localparam int SH = TAPS - 1;

    logic signed [AW-1:0] prod [TAPS];
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] scaled;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        localparam logic signed [AW-1:0] COEF = AW'(binom(TAPS - 1, k));
        logic signed [AW-1:0] tx;
        assign tx      = AW'($signed(taps[k]));
        assign prod[k] = tx * COEF;
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            acc = acc + prod[k];
        end
        scaled = acc >>> SH;
        y      = scaled[W-1:0];
    end
endmodule

// File: rtl/decim_seq.sv
// Channel and frame-phase sequencer; emit marks frames with phase 0.
module decim_seq #(
    parameter int NUM_CH = 62,
    parameter int DECIM  = 40,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int PH_W   = $clog2(DECIM)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [CH_W-1:0] ch,
    output logic            emit
);
    typedef struct packed {
        logic [CH_W-1:0] ch;
        logic [PH_W-1:0] ph;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (step) begin
            if (seq_q.ch == CH_W'(NUM_CH - 1)) begin
                seq_d.ch = '0;
                seq_d.ph = (seq_q.ph == PH_W'(DECIM - 1)) ? '0 : seq_q.ph + 1'b1;
            end else begin
                seq_d.ch = seq_q.ch + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign ch   = seq_q.ch;
    assign emit = (seq_q.ph == '0);
endmodule

// File: rtl/eeg_prep_decim.sv
module eeg_prep_decim #(
    parameter int NUM_CH  = 62,
    parameter int DATA_W  = 16,
    parameter int DECIM   = 40,
    parameter int TAPS    = 4,
    parameter int NOTCH_K = 8,
    parameter int CH_W    = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [CH_W-1:0]   out_ch
);
    localparam int PH_W = $clog2(DECIM);
    localparam int DL_N = TAPS - 1;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [CH_W-1:0]   ch;
    } oreg_t;

    oreg_t o_d, o_q;

    logic            accept;
    logic [CH_W-1:0] cur_ch;
    logic            emit;

    // Per-channel history arrays, addressed by channel number.
    logic [DATA_W-1:0]           x1_mem [NUM_CH];
    logic [DATA_W-1:0]           y1_mem [NUM_CH];
    logic [DL_N-1:0][DATA_W-1:0] dl_mem [NUM_CH];

    logic [DL_N-1:0][DATA_W-1:0] dl_rd, dl_wr;
    logic [TAPS-1:0][DATA_W-1:0] taps;
    logic [DATA_W-1:0]           hp_y, lp_y;

    assign in_ready = !o_q.valid || out_ready;
    assign accept   = in_valid && in_ready;

    decim_seq #(
        .NUM_CH(NUM_CH), .DECIM(DECIM), .CH_W(CH_W), .PH_W(PH_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .step(accept), .ch(cur_ch), .emit(emit)
    );

    dc_notch #(.W(DATA_W), .K(NOTCH_K)) u_notch (
        .x(in_data), .x_prev(x1_mem[cur_ch]), .y_prev(y1_mem[cur_ch]), .y(hp_y)
    );

    always_comb begin
        dl_rd   = dl_mem[cur_ch];
        taps[0] = hp_y;
        for (int k = 1; k < TAPS; k++) taps[k] = dl_rd[k-1];
        dl_wr[0] = hp_y;
        for (int k = 1; k < DL_N; k++) dl_wr[k] = dl_rd[k-1];
    end

    fir_binomial #(.W(DATA_W), .TAPS(TAPS)) u_fir (
        .taps(taps), .y(lp_y)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                x1_mem[c] <= '0;
                y1_mem[c] <= '0;
                dl_mem[c] <= '0;
            end
        end else if (accept) begin
            x1_mem[cur_ch] <= in_data;
            y1_mem[cur_ch] <= hp_y;
            dl_mem[cur_ch] <= dl_wr;
        end
    end

    always_comb begin
        o_d = o_q;
        if (o_q.valid && out_ready) o_d.valid = 1'b0;
        if (accept && emit) begin
            o_d.valid = 1'b1;
            o_d.data  = lp_y;
            o_d.ch    = cur_ch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.valid;
    assign out_data  = o_q.data;
    assign out_ch    = o_q.ch;
endmodule

// File: rtl/eeg_prep_decim_chk.sv
module eeg_prep_decim_chk #(
    parameter int NUM_CH = 62,
    parameter int DECIM  = 40,
    parameter int DATA_W = 16,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [CH_W-1:0]   out_ch
);
    localparam int GRP = NUM_CH * DECIM;
    localparam int CW  = $clog2(GRP + 1);

    logic          acc;
    logic [CW-1:0] cnt_q;

    assign acc = in_valid && in_ready;

    // Position of the next accepted sample within a group of DECIM frames.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (acc && cnt_q == CW'(GRP-1)) cnt_q <= '0;
        else if (acc)                       cnt_q <= cnt_q + 1'b1;
    end

    a_r1_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    a_r7_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ch)));

    a_r5_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cnt_q >= CW'(NUM_CH)) |=> !out_valid);

    a_r5_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cnt_q < CW'(NUM_CH)) |=> (out_valid && out_ch == $past(cnt_q[CH_W-1:0])));

    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !out_valid) |=> !out_valid);

    a_r6_ch_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ch < CH_W'(NUM_CH)));
endmodule

bind eeg_prep_decim eeg_prep_decim_chk #(
    .NUM_CH(NUM_CH), .DECIM(DECIM), .DATA_W(DATA_W), .CH_W(CH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ch(out_ch)
);

// File: tb/sim_eeg_prep_decim.sv
module sim_eeg_prep_decim;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH  = 62;
    localparam int DATA_W  = 16;
    localparam int DECIM   = 40;
    localparam int TAPS    = 4;
    localparam int NOTCH_K = 8;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int N_CYC   = 30000;
    localparam int SMAX    = (1 << (DATA_W - 1)) - 1;
    localparam int SMIN    = -(1 << (DATA_W - 1));

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DATA_W-1:0] out_data;
    logic [CH_W-1:0]   out_ch;

    int checks = 0;
    int errors = 0;

    // Reference state
    int xh [NUM_CH];
    int yh [NUM_CH];
    int hist [NUM_CH][TAPS];
    int coef [TAPS];
    int mch, mph;
    bit mv;
    int mdata, mchan;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeg_prep_decim #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .DECIM(DECIM), .TAPS(TAPS), .NOTCH_K(NOTCH_K)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_ch(out_ch)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string seg_tag(input int cyc);
        if (cyc < 6000)  return "R2";
        if (cyc < 12000) return "R3";
        if (cyc < 18000) return "R9";
        return "R7";
    endfunction

    // Advance the reference by one clock edge given the driven inputs.
    task automatic model_step(input bit iv, input bit ordy, input int x);
        bit rdy;
        int v, s, r;
        rdy = !mv || ordy;
        if (mv && ordy) mv = 1'b0;
        if (iv && rdy) begin
            v = x - xh[mch] + yh[mch] - (yh[mch] >>> NOTCH_K);
            if (v > SMAX) v = SMAX;
            if (v < SMIN) v = SMIN;
            for (int k = TAPS - 1; k > 0; k--) hist[mch][k] = hist[mch][k-1];
            hist[mch][0] = v;
            s = 0;
            for (int k = 0; k < TAPS; k++) s += coef[k] * hist[mch][k];
            r = s >>> (TAPS - 1);
            xh[mch] = x;
            yh[mch] = v;
            if (mph == 0) begin
                mv = 1'b1;
                mdata = r;
                mchan = mch;
            end
            if (mch == NUM_CH - 1) begin
                mch = 0;
                mph = (mph == DECIM - 1) ? 0 : mph + 1;
            end else begin
                mch++;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Binomial weights by Pascal's rule
        for (int k = 0; k < TAPS; k++) coef[k] = 0;
        coef[0] = 1;
        for (int n = 1; n < TAPS; n++)
            for (int k = n; k > 0; k--) coef[k] = coef[k] + coef[k-1];
        for (int c = 0; c < NUM_CH; c++) begin
            xh[c] = 0; yh[c] = 0;
            for (int k = 0; k < TAPS; k++) hist[c][k] = 0;
        end
        mch = 0; mph = 0; mv = 1'b0; mdata = 0; mchan = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state seen at the ports
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(in_ready == 1'b1, "R1", in_ready, 1);

        for (int cyc = 0; cyc < N_CYC; cyc++) begin
            bit iv, ordy;
            int x;
            string tag;
            tag = seg_tag(cyc);
            // Registered outputs against the reference (R5 valid, R4/R6 channel)
            check(out_valid == mv, "R5", out_valid, mv);
            if (mv) begin
                check(int'(out_ch) == mchan, (cyc < 6000) ? "R4" : "R6", out_ch, mchan);
                check($signed(out_data) == mdata, tag, $signed(out_data), mdata);
            end
            // Choose stimulus
            if (cyc < 6000) begin
                iv = 1'b1; ordy = 1'b1;
                x = 1000 * (mch % 7) - 3000 + (cyc % 5);
            end else if (cyc < 12000) begin
                // R8: idle cycles mixed in
                iv = ($urandom % 4) != 0;
                ordy = ($urandom % 2) != 0;
                x = int'($signed(16'($urandom)));
            end else if (cyc < 18000) begin
                iv = 1'b1; ordy = 1'b1;
                x = ((cyc / NUM_CH) % 2) ? SMAX : SMIN;
            end else begin
                iv = 1'b1;
                ordy = (cyc % 50) >= 40;
                x = mch * 100 + (((cyc / 7) % 2) ? 5000 : -5000);
            end
            in_valid  = iv;
            out_ready = ordy;
            in_data   = DATA_W'(x);
            #1;
            // R7: ready follows the output register and consumer
            check(in_ready == (!mv || ordy), "R7", in_ready, !mv || ordy);
            model_step(iv, ordy, x);
            @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule